// File: doc/BRIEF.md
# Fuzzy Acceptance-Rate Bus Arbiter

This block shares one bus among three masters. It does not look only at who is requesting now. It also remembers, for each master, how many cycles it asked for the bus and how many of those cycles it was granted. From these two counts a background divider derives a percentage acceptance rate, one master at a time. Triangular membership functions grade that rate as low, medium or high, and the rate is given the category with the strongest membership. A fixed 27-entry rule set then names the master whose rate category is worst. Ties go to the master with the lower index.

The grant is combinational. It is built from the current request lines and the most recently finished category of each master, so a request is answered in the same cycle. Bit 0 of the request and grant vectors belongs to the highest-priority master, and bit 2 to the lowest. Either counter stops at its maximum instead of wrapping. A master that has never requested counts as fully served, with a rate of 100.

Top module: `fz_rate_arbiter`

## Requirements
- R1: The rate of master i is floor(granted_i * 100 / requested_i), or 100 when requested_i is zero. It is recomputed for each master at least once every 30 cycles, and the grant uses the latest completed value.
- R2: A rate of 0..24 is category low, 25..54 is medium, and 55..100 is high. These bands follow from triangles with corner points 0, 18, 36 and 72 (low: full at 0, zero from 36; medium: rising from 18 to a peak at 36, zero from 72; high: rising from 36, full from 72), with ties resolved toward the lower set.
- R3: When master 0 is low, the rule picks master 0.
- R4: When master 0 is medium, the rule picks master 1 if master 1 is low. Otherwise it picks master 2 if master 2 is low. Otherwise it picks master 0.
- R5: When master 0 is high, the rule picks master 1 if master 1 is low. If master 1 is medium, it picks master 2 if master 2 is low, else master 1. If master 1 is high, it picks master 2 if master 2 is low or medium, else master 0.
- R6: At most one grant line is high, and only a requesting master is granted. If the picked master is not requesting, the lowest-index requester is granted instead. With no requests there is no grant, and with any request there is exactly one grant.
- R7: A request counter adds one in each cycle its request line is high. A grant counter adds one in each cycle its grant line is high. Both stop at 2^CNT_W-1.
- R8: After reset every category is high, so the first contested request goes to the lowest-index requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 3 | Request lines, bit 0 highest priority |
| gnt | output | 3 | One-hot grant lines, combinational from req and stored categories |

## Verification
A wrong counter, divider step or membership slope does not show up at once. It shows up as a grant to the wrong master in a later contested cycle, once the bad value has moved a master across a category band. That can take up to a full 30-cycle refresh sweep. The bench therefore separates contested probes with idle gaps long enough for every rate to be refreshed. It tracks the counts itself and predicts each contested winner from the rate, band and rule definitions. A fault in the saturation logic is exposed by driving a counter to its limit and then piling up denials until a wrapped count would have crossed into medium.

// File: rtl/fzarb_pkg.sv
package fzarb_pkg;
  localparam int unsigned NM   = 3;
  localparam int unsigned IDXW = 2;
  localparam int unsigned QW   = 8;
  localparam logic [1:0] CAT_LO = 2'd0;
  localparam logic [1:0] CAT_MD = 2'd1;
  localparam logic [1:0] CAT_HI = 2'd2;
  localparam logic [QW-1:0] FULL_RATE = 8'd100;
endpackage

// File: rtl/fzarb_divider.sv
module fzarb_divider
  import fzarb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NM-1:0][CNT_W-1:0]   req_cnt,
  input  logic [NM-1:0][CNT_W-1:0]   gnt_cnt,
  output logic                       done,
  output logic [IDXW-1:0]            done_idx,
  output logic [QW-1:0]              rate
);
  localparam int unsigned DW = CNT_W + QW;
  typedef enum logic [1:0] {ST_LOAD, ST_ITER, ST_DONE} st_t;

  st_t               st_q, st_d;
  logic [IDXW-1:0]   idx_q, idx_d;
  logic [2:0]        step_q, step_d;
  logic [DW-1:0]     rem_q, rem_d;
  logic [CNT_W-1:0]  den_q, den_d;
  logic [QW-1:0]     quo_q, quo_d;
  logic [DW-1:0]     shifted;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    step_d  = step_q;
    rem_d   = rem_q;
    den_d   = den_q;
    quo_d   = quo_q;
    done    = 1'b0;
    shifted = DW'(den_q) << step_q;
    case (st_q)
      ST_LOAD: begin
        rem_d  = DW'(gnt_cnt[idx_q]) * DW'(100);
        den_d  = req_cnt[idx_q];
        quo_d  = '0;
        step_d = 3'(QW - 1);
        st_d   = ST_ITER;
      end
      ST_ITER: begin
        if (rem_q >= shifted) begin
          rem_d         = rem_q - shifted;
          quo_d[step_q] = 1'b1;
        end
        if (step_q == 3'd0) st_d = ST_DONE;
        else                step_d = step_q - 3'd1;
      end
      default: begin
        done  = 1'b1;
        st_d  = ST_LOAD;
        idx_d = (idx_q == IDXW'(NM - 1)) ? '0 : idx_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOAD;
      idx_q  <= '0;
      step_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      step_q <= step_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      quo_q  <= quo_d;
    end
  end

  assign done_idx = idx_q;
  assign rate     = (den_q == '0) ? FULL_RATE : quo_q;

  // R1: a finished percentage never exceeds full acceptance
  assert_rate_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rate <= FULL_RATE));
endmodule

// File: rtl/fzarb_fuzzify.sv
module fzarb_fuzzify
  import fzarb_pkg::*;
#(
  parameter int BP_RISE = 18,
  parameter int BP_PEAK = 36,
  parameter int BP_TOP  = 72
) (
  input  logic [QW-1:0] rate,
  output logic [1:0]    cat
);
  localparam int SCALE = BP_PEAK * (BP_PEAK - BP_RISE) * (BP_TOP - BP_PEAK);
  localparam int K_LO  = SCALE / BP_PEAK;
  localparam int K_MDL = SCALE / (BP_PEAK - BP_RISE);
  localparam int K_MDR = SCALE / (BP_TOP - BP_PEAK);
  localparam int K_HI  = SCALE / (BP_TOP - BP_PEAK);

  int x, mu_lo, mu_md, mu_hi, best;

  always_comb begin
    x = int'(rate);
    mu_lo = (x < BP_PEAK) ? (BP_PEAK - x) * K_LO : 0;
    if (x >= BP_RISE && x < BP_PEAK)     mu_md = (x - BP_RISE) * K_MDL;
    else if (x >= BP_PEAK && x < BP_TOP) mu_md = (BP_TOP - x) * K_MDR;
    else                                 mu_md = 0;
    if (x >= BP_TOP)       mu_hi = SCALE;
    else if (x >= BP_PEAK) mu_hi = (x - BP_PEAK) * K_HI;
    else                   mu_hi = 0;
    cat  = CAT_LO;
    best = mu_lo;
    if (mu_md > best) begin
      cat  = CAT_MD;
      best = mu_md;
    end
    if (mu_hi > best) cat = CAT_HI;
  end
endmodule

// File: rtl/fzarb_rules.sv
module fzarb_rules
  import fzarb_pkg::*;
(
  input  logic [NM-1:0][1:0] cats,
  input  logic [NM-1:0]      req,
  output logic [NM-1:0]      gnt
);
  logic [IDXW-1:0] pick;
  logic [NM-1:0]   pick_oh;

  always_comb begin
    case (cats[0])
      CAT_LO: pick = 2'd0;
      CAT_MD: pick = (cats[1] == CAT_LO) ? 2'd1 :
                     (cats[2] == CAT_LO) ? 2'd2 : 2'd0;
      default: begin
        if (cats[1] == CAT_LO)      pick = 2'd1;
        else if (cats[1] == CAT_MD) pick = (cats[2] == CAT_LO) ? 2'd2 : 2'd1;
        else                        pick = (cats[2] != CAT_HI) ? 2'd2 : 2'd0;
      end
    endcase
    pick_oh = NM'(1) << pick;
    if ((pick_oh & req) != '0) gnt = pick_oh;
    else                       gnt = req & (~req + NM'(1));
  end
endmodule

// File: rtl/fz_rate_arbiter.sv
module fz_rate_arbiter
  import fzarb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  output logic [NM-1:0] gnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]                sync_q;
  logic                      rst_s;
  logic [NM-1:0][CNT_W-1:0]  req_cnt_q, req_cnt_d, gnt_cnt_q, gnt_cnt_d;
  logic [NM-1:0][1:0]        cat_q;
  logic                      dv_done;
  logic [IDXW-1:0]           dv_idx;
  logic [QW-1:0]             dv_rate;
  logic [1:0]                dv_cat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s = sync_q[1];

  for (genvar i = 0; i < NM; i++) begin : g_cnt
    always_comb begin
      req_cnt_d[i] = req_cnt_q[i];
      gnt_cnt_d[i] = gnt_cnt_q[i];
      if (req[i] && req_cnt_q[i] != CNT_MAX) req_cnt_d[i] = req_cnt_q[i] + 1'b1;
      if (gnt[i] && gnt_cnt_q[i] != CNT_MAX) gnt_cnt_d[i] = gnt_cnt_q[i] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        req_cnt_q[i] <= '0;
        gnt_cnt_q[i] <= '0;
        cat_q[i]     <= CAT_HI;
      end else begin
        req_cnt_q[i] <= req_cnt_d[i];
        gnt_cnt_q[i] <= gnt_cnt_d[i];
        if (dv_done && dv_idx == IDXW'(i)) cat_q[i] <= dv_cat;
      end
    end

    // R7: a saturated counter holds its limit
    assert_req_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_s)
      ($past(req_cnt_q[i]) == CNT_MAX) |-> (req_cnt_q[i] == CNT_MAX));
    // R7: grants never outnumber requests
    assert_gnt_le_req_R7: assert property (@(posedge clk) disable iff (!rst_s)
      gnt_cnt_q[i] <= req_cnt_q[i]);
  end

  fzarb_divider #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_s),
    .req_cnt  (req_cnt_q),
    .gnt_cnt  (gnt_cnt_q),
    .done     (dv_done),
    .done_idx (dv_idx),
    .rate     (dv_rate)
  );

  fzarb_fuzzify u_fuzz (
    .rate (dv_rate),
    .cat  (dv_cat)
  );

  fzarb_rules u_rules (
    .cats (cat_q),
    .req  (req),
    .gnt  (gnt)
  );

  // R6: grant lines are exclusive
  assert_gnt_onehot_R6: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(gnt));
  // R6: only requesters are granted
  assert_gnt_only_req_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (gnt & ~req) == '0);
  // R6: a pending request is always served
  assert_gnt_when_req_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (req != '0) |-> ($countones(gnt) == 1));
  // R2: a stored category is always one of the three sets
  assert_cat_legal_R2: assert property (@(posedge clk) disable iff (!rst_s)
    dv_done |-> (dv_cat != 2'd3));
endmodule

// File: tb/fz_rate_arbiter_tb.sv
module fz_rate_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int CMAX       = (1 << CNT_W) - 1;
  localparam int SETTLE     = 48;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] req;
  logic [2:0] gnt;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int m_req[3];
  int m_gnt[3];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fz_rate_arbiter #(.CNT_W(CNT_W)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
  );

  function automatic int rate_of(int i);   // R1
    if (m_req[i] == 0) return 100;
    return (m_gnt[i] * 100) / m_req[i];
  endfunction

  function automatic int cat_of(int r);    // R2: 0 low, 1 medium, 2 high
    if (r <= 24) return 0;
    if (r <= 54) return 1;
    return 2;
  endfunction

  function automatic int rule_pick(int c0, int c1, int c2);
    if (c0 == 0) return 0;                                   // R3
    if (c0 == 1) return (c1 == 0) ? 1 : (c2 == 0) ? 2 : 0;   // R4
    if (c1 == 0) return 1;                                   // R5
    if (c1 == 1) return (c2 == 0) ? 2 : 1;
    return (c2 != 2) ? 2 : 0;
  endfunction

  task automatic do_reset();
    req   = 3'b000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    n_vec++;
    if (gnt !== 3'b000) begin
      n_fail++;
      $display("FAIL R6 reset idle grant actual=%b expected=000", gnt);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      m_req[i] = 0;
      m_gnt[i] = 0;
    end
  endtask

  task automatic cycle_check(logic [2:0] mask, string tag);
    int w;
    logic [2:0] exp;
    int c0, c1, c2;
    @(negedge clk);
    req = mask;
    c0 = cat_of(rate_of(0));
    c1 = cat_of(rate_of(1));
    c2 = cat_of(rate_of(2));
    w = rule_pick(c0, c1, c2);
    if (mask == 3'b000) exp = 3'b000;
    else if (mask[w]) exp = 3'(1 << w);
    else exp = mask & (~mask + 3'd1);                        // R6 fallback
    #(CLK_PERIOD/4);
    n_vec++;
    if (gnt !== exp) begin
      n_fail++;
      $display("FAIL %s cats=%0d%0d%0d req=%b actual=%b expected=%b",
               tag, c0, c1, c2, mask, gnt, exp);
    end
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin                        // R7 saturating model
      if (mask[i] && m_req[i] < CMAX) m_req[i]++;
      if (exp[i]  && m_gnt[i] < CMAX) m_gnt[i]++;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    req = 3'b000;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic probe(logic [2:0] mask, string tag);
    cycle_check(mask, tag);
    settle();
  endtask

  task automatic burst(int m, int n);
    for (int k = 0; k < n; k++) cycle_check(3'(1 << m), "R6_single");
    settle();
  endtask

  // R8: after reset everyone is high, lowest-index requester wins
  task automatic t_reset_state();
    do_reset();
    probe(3'b111, "R8_all");
    do_reset();
    probe(3'b110, "R8_upper");
    probe(3'b000, "R6_none");
  endtask

  // R1 R2 R4 R5: step rates across bands with contested pairs
  task automatic t_rate_ladder();
    do_reset();
    burst(0, 1);
    for (int k = 0; k < 8; k++) probe(3'b011, "R5_pair01");
    for (int k = 0; k < 6; k++) probe(3'b101, "R4_pair02");
    for (int k = 0; k < 6; k++) probe(3'b111, "R1_all");
    for (int k = 0; k < 4; k++) probe(3'b110, "R2_pair12");
  endtask

  // R3 R4 R5 R6: pseudo-random contention with short single bursts
  task automatic t_random_mix();
    do_reset();
    for (int k = 0; k < 90; k++) begin
      logic [2:0] mk;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mk = lfsr[2:0];
      if ($countones(mk) == 1) burst(int'(lfsr[4:3]) % 3, 1 + int'(lfsr[6:5]));
      else probe(mk, "R3_R4_R5_mix");
    end
  endtask

  // R7: saturated counters keep a fully served master high despite denials
  task automatic t_saturation();
    do_reset();
    burst(2, 300);
    burst(0, 2);
    for (int k = 0; k < 40; k++) probe(3'b101, "R7_sat");
  endtask

  initial begin
    t_reset_state();
    t_rate_ladder();
    t_random_mix();
    t_saturation();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule